// File: doc/BRIEF.md
# Key-Protected SRAM Erase and Lock Controller

This block is a small system-configuration slave on a simple register bus. It holds a set of sticky lock bits and a hardware-set SRAM parity-error flag. It also owns a hardware engine that clears a local SRAM by writing zero to every word. Software can start the erase only after it has written a two-word key to a dedicated key register. The key is spent by the start that it enables.

One of the lock bits, the ECC lock (the highest lock bit), also acts as a gate. While it is set, the flash ECC error input is passed straight through to a break output that feeds timer logic. While it is clear, the break output stays low. Lock bits can only be set by software. Only a reset clears them.

The register map uses three byte offsets: the lock/flag register at 0x1C, the erase register at 0x20 and the key register at 0x24. Reads are combinational on the addressed word. Writes take effect at the clock edge on which select and write are both high.

Top module: `cfgEraseLock`

## Requirements
- R1: After reset, every register reads 0, `breakOut` is 0 and `memWe` is 0.
- R2: Lock/flag register bits 3:0 are lock bits. Writing 1 to a bit sets it. Writing 0 has no effect. Only reset clears a lock bit.
- R3: `breakOut` equals `eccErr` while lock bit 3 is 1, and is 0 while lock bit 3 is 0.
- R4: Lock/flag register bit 8 is the parity flag. It is set in the cycle after `parityErr` is high. Writing 1 to bit 8 clears it, and writing 0 to bit 8 leaves it unchanged.
- R5: If `parityErr` is high in the same cycle as a write of 1 to bit 8, the flag stays set.
- R6: Reserved bits of every register read 0, and writes to them are ignored. The key register and unmapped offsets read 0.
- R7: A write of 1 to erase register bit 0 starts an erase only when the two writes just before it were 0xCA and then 0x53 to the key register.
- R8: A wrong key value, or any other write between the two key words, or between the key and the start, leaves the erase locked.
- R9: An accepted start uses up the unlock, so a later start needs a fresh key sequence.
- R10: An accepted start raises busy on the next cycle. The engine then asserts `memWe` for exactly MEM_DEPTH cycles, with `memAddr` running 0, 1, … MEM_DEPTH-1 and `memWdata` equal to 0. Erase register bits 0 (start) and 1 (busy) read 1 throughout the erase and 0 once it has finished.
- R11: A correctly keyed start issued while an erase is running is ignored. The running erase neither restarts nor lengthens.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busSel | input | 1 | Register access valid |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | ADDR_W | Byte offset of the register |
| busWdata | input | DATA_W | Write data |
| busRdata | output | DATA_W | Read data for the addressed register |
| parityErr | input | 1 | SRAM parity error pulse |
| eccErr | input | 1 | Flash ECC error |
| breakOut | output | 1 | Gated ECC error toward timer break |
| memWe | output | 1 | SRAM write enable from erase engine |
| memAddr | output | MEM_AW | SRAM word address from erase engine |
| memWdata | output | DATA_W | SRAM write data (always zero) |

## Verification
The hardest case to reach is a second, fully keyed start that arrives while an erase is already in progress. It needs three writes to land inside the busy window. The bench shrinks the SRAM depth to 16 words and issues the unlock and start right after the first start. It then checks that the total number of word writes and the moment busy falls still match a single erase. The parity flag's set-versus-clear collision is reached both by a directed cycle and by random cycles that mix parity pulses with random write-1 data.

// File: rtl/cfgEraseLockPkg.sv
`timescale 1ns/1ps
package cfgEraseLockPkg;

  typedef struct packed {
    logic lockWr;     // write to lock/flag register
    logic flagClr;    // write-1 to parity flag bit
    logic eraseGo;    // accepted, keyed erase start
    logic eraseStep;  // engine writes one word this cycle
  } strobeT;

  typedef enum logic [1:0] {
    KEY_IDLE = 2'd0,
    KEY_HALF = 2'd1,
    KEY_OPEN = 2'd2
  } keyStateT;

endpackage

// File: rtl/cfgEraseCtrl.sv
`timescale 1ns/1ps
module cfgEraseCtrl
  import cfgEraseLockPkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32,
  parameter int FLAG_BIT = 8,
  parameter logic [ADDR_W-1:0] LOCK_OFS  = 'h1C,
  parameter logic [ADDR_W-1:0] ERASE_OFS = 'h20,
  parameter logic [ADDR_W-1:0] KEY_OFS   = 'h24,
  parameter logic [7:0] KEY_FIRST  = 8'hCA,
  parameter logic [7:0] KEY_SECOND = 8'h53
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  input  logic              lastAddr,
  output logic              busy,
  output strobeT            strobe
);

  localparam logic [DATA_W-1:0] KEY_A = DATA_W'(KEY_FIRST);
  localparam logic [DATA_W-1:0] KEY_B = DATA_W'(KEY_SECOND);

  keyStateT keyQ, keyNext;
  logic     busyQ;
  logic     wrEn, hitLock, hitErase, hitKey;

  assign wrEn     = busSel & busWrite;
  assign hitLock  = (busAddr == LOCK_OFS);
  assign hitErase = (busAddr == ERASE_OFS);
  assign hitKey   = (busAddr == KEY_OFS);

  // Key sequencer: every write advances or drops the unlock state.
  always_comb begin
    keyNext = keyQ;
    if (wrEn) begin
      if (hitKey && busWdata == KEY_A)
        keyNext = KEY_HALF;
      else if (hitKey && busWdata == KEY_B && keyQ == KEY_HALF)
        keyNext = KEY_OPEN;
      else
        keyNext = KEY_IDLE;
    end
  end

  always_comb begin
    strobe.lockWr    = wrEn & hitLock;
    strobe.flagClr   = wrEn & hitLock & busWdata[FLAG_BIT];
    strobe.eraseGo   = wrEn & hitErase & busWdata[0] & (keyQ == KEY_OPEN) & ~busyQ;
    strobe.eraseStep = busyQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      keyQ  <= KEY_IDLE;
      busyQ <= 1'b0;
    end else begin
      keyQ <= keyNext;
      if (strobe.eraseGo)
        busyQ <= 1'b1;
      else if (busyQ && lastAddr)
        busyQ <= 1'b0;
    end
  end

  assign busy = busyQ;

  // Busy only starts from an open key and a write to the erase register.
  p_start_keyed_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busyQ) |-> ($past(keyQ) == KEY_OPEN) && $past(wrEn && hitErase));

  // The starting write spends the unlock.
  p_key_spent_r9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busyQ) |-> keyQ != KEY_OPEN);

  // A running erase continues until the last address.
  p_busy_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    (busyQ && !lastAddr) |=> busyQ);

endmodule

// File: rtl/cfgEraseData.sv
`timescale 1ns/1ps
module cfgEraseData
  import cfgEraseLockPkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32,
  parameter int LOCK_N    = 4,
  parameter int FLAG_BIT  = 8,
  parameter int MEM_DEPTH = 64,
  parameter int MEM_AW    = $clog2(MEM_DEPTH),
  parameter logic [ADDR_W-1:0] LOCK_OFS  = 'h1C,
  parameter logic [ADDR_W-1:0] ERASE_OFS = 'h20
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobeT            strobe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  input  logic              parityErr,
  input  logic              busy,
  output logic [DATA_W-1:0] busRdata,
  output logic              lastAddr,
  output logic              eccLock,
  output logic [MEM_AW-1:0] memAddr
);

  localparam logic [MEM_AW-1:0] LAST = MEM_AW'(MEM_DEPTH - 1);

  logic [LOCK_N-1:0] lockQ;
  logic              flagQ;
  logic [MEM_AW-1:0] eraseAddr;

  wire unusedWdata = ^{busWdata[DATA_W-1:FLAG_BIT+1], busWdata[FLAG_BIT-1:LOCK_N]};

  // Sticky lock bits: set per bit, cleared only by reset.
  genvar gi;
  generate
    for (gi = 0; gi < LOCK_N; gi++) begin : g_lock
      always_ff @(posedge clk) begin
        if (!rstN)
          lockQ[gi] <= 1'b0;
        else if (strobe.lockWr && busWdata[gi])
          lockQ[gi] <= 1'b1;
      end
    end
  endgenerate

  // Parity flag: hardware set wins over software clear.
  always_ff @(posedge clk) begin
    if (!rstN)
      flagQ <= 1'b0;
    else if (parityErr)
      flagQ <= 1'b1;
    else if (strobe.flagClr)
      flagQ <= 1'b0;
  end

  // Erase address walker.
  always_ff @(posedge clk) begin
    if (!rstN)
      eraseAddr <= '0;
    else if (strobe.eraseGo)
      eraseAddr <= '0;
    else if (strobe.eraseStep && !lastAddr)
      eraseAddr <= eraseAddr + 1'b1;
  end

  assign lastAddr = (eraseAddr == LAST);
  assign memAddr  = eraseAddr;
  assign eccLock  = lockQ[LOCK_N-1];

  always_comb begin
    busRdata = '0;
    if (busAddr == LOCK_OFS) begin
      busRdata[LOCK_N-1:0] = lockQ;
      busRdata[FLAG_BIT]   = flagQ;
    end else if (busAddr == ERASE_OFS) begin
      busRdata[1:0] = {busy, busy};
    end
  end

  // Lock bits never fall outside reset.
  p_lock_sticky_r2: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((lockQ | $past(lockQ)) == lockQ));

  // A parity pulse always leaves the flag set.
  p_flag_priority_r5: assert property (@(posedge clk) disable iff (!rstN)
    parityErr |=> flagQ);

  // Each erase begins at word 0.
  p_addr_start_r10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(strobe.eraseStep) |-> eraseAddr == '0);

  // Addresses advance by one per written word.
  p_addr_walk_r10: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.eraseStep && !lastAddr) |=> eraseAddr == $past(eraseAddr) + 1'b1);

endmodule

// File: rtl/cfgEraseLock.sv
`timescale 1ns/1ps
module cfgEraseLock
  import cfgEraseLockPkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32,
  parameter int LOCK_N    = 4,
  parameter int FLAG_BIT  = 8,
  parameter int MEM_DEPTH = 64,
  parameter int MEM_AW    = $clog2(MEM_DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic              parityErr,
  input  logic              eccErr,
  output logic              breakOut,
  output logic              memWe,
  output logic [MEM_AW-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata
);

  localparam logic [ADDR_W-1:0] LOCK_OFS  = ADDR_W'('h1C);
  localparam logic [ADDR_W-1:0] ERASE_OFS = ADDR_W'('h20);
  localparam logic [ADDR_W-1:0] KEY_OFS   = ADDR_W'('h24);

  strobeT strobe;
  logic   busy, lastAddr, eccLock;

  cfgEraseCtrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .FLAG_BIT(FLAG_BIT),
    .LOCK_OFS(LOCK_OFS), .ERASE_OFS(ERASE_OFS), .KEY_OFS(KEY_OFS)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .lastAddr(lastAddr),
    .busy(busy), .strobe(strobe)
  );

  cfgEraseData #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LOCK_N(LOCK_N), .FLAG_BIT(FLAG_BIT),
    .MEM_DEPTH(MEM_DEPTH), .MEM_AW(MEM_AW),
    .LOCK_OFS(LOCK_OFS), .ERASE_OFS(ERASE_OFS)
  ) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .busAddr(busAddr),
    .busWdata(busWdata), .parityErr(parityErr), .busy(busy),
    .busRdata(busRdata), .lastAddr(lastAddr), .eccLock(eccLock),
    .memAddr(memAddr)
  );

  assign breakOut = eccLock & eccErr;
  assign memWe    = strobe.eraseStep;
  assign memWdata = '0;

  // No ECC error, no break.
  p_break_quiet_r3: assert property (@(posedge clk) disable iff (!rstN)
    !eccErr |-> !breakOut);

endmodule

// File: tb/tb_cfgEraseLock.sv
`timescale 1ns/1ps
module tb_cfgEraseLock;

  localparam int DEPTH = 16;
  localparam int AW    = $clog2(DEPTH);
  localparam logic [7:0] A_LOCK  = 8'h1C;
  localparam logic [7:0] A_ERASE = 8'h20;
  localparam logic [7:0] A_KEY   = 8'h24;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          busSel = 1'b0, busWrite = 1'b0;
  logic [7:0]    busAddr = 8'h00;
  logic [31:0]   busWdata = '0;
  logic [31:0]   busRdata;
  logic          parityErr = 1'b0, eccErr = 1'b0;
  logic          breakOut, memWe;
  logic [AW-1:0] memAddr;
  logic [31:0]   memWdata;

  int tests = 0, fails = 0;
  int weCount = 0, addrErr = 0;
  bit done = 1'b0;

  cfgEraseLock #(.MEM_DEPTH(DEPTH)) dut (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .parityErr(parityErr), .eccErr(eccErr), .breakOut(breakOut),
    .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata)
  );

  always #2.5 clk = ~clk;

  always @(negedge clk) begin
    if (memWe) begin
      if (memAddr !== AW'(weCount) || memWdata !== 32'h0) addrErr++;
      weCount++;
    end
  end

  function automatic logic [31:0] lockReg(logic [3:0] lk, logic fl);
    lockReg = {23'h0, fl, 4'h0, lk};
  endfunction

  function automatic logic nextFlag(logic fl, logic par, logic wr, logic [31:0] wd);
    if (par) nextFlag = 1'b1;
    else if (wr && wd[8]) nextFlag = 1'b0;
    else nextFlag = fl;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic busWr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    busSel = 1'b1; busWrite = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 1'b0; busWrite = 1'b0;
  endtask

  task automatic rdReg(logic [7:0] a, output logic [31:0] d);
    busAddr = a;
    #1;
    d = busRdata;
  endtask

  task automatic unlock();
    busWr(A_KEY, 32'hCA);
    busWr(A_KEY, 32'h53);
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: got 0x%08h expected 0x%08h", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    logic [3:0]  lockExp;
    logic        flagExp;
    void'($urandom(32'h1234_5eed));
    doReset();

    // R1 reset state
    rdReg(A_LOCK, rd);  chk("R1 lock reg", rd, 32'h0);
    rdReg(A_ERASE, rd); chk("R1 erase reg", rd, 32'h0);
    chk("R1 breakOut", {31'h0, breakOut}, 32'h0);
    chk("R1 memWe", {31'h0, memWe}, 32'h0);

    // Random phase: R2 R3 R4 R5 against a bench model
    lockExp = 4'h0; flagExp = 1'b0;
    for (int i = 0; i < 400; i++) begin
      logic par, ecc, doWr;
      logic [31:0] wd;
      @(negedge clk);
      rdReg(A_LOCK, rd);
      chk("R2/R4 random lock reg", rd, lockReg(lockExp, flagExp));
      par  = ($urandom % 5) == 0;
      ecc  = $urandom % 2;
      doWr = ($urandom % 3) == 0;
      wd   = $urandom;
      wd[3:0] = wd[3:0] & 4'($urandom) & 4'($urandom);
      parityErr = par; eccErr = ecc;
      busSel = doWr; busWrite = doWr; busAddr = A_LOCK; busWdata = wd;
      #1;
      chk("R3 random breakOut", {31'h0, breakOut}, {31'h0, lockExp[3] & ecc});
      if (doWr) lockExp = lockExp | wd[3:0];
      flagExp = nextFlag(flagExp, par, doWr, wd);
    end
    @(negedge clk);
    busSel = 1'b0; busWrite = 1'b0; parityErr = 1'b0; eccErr = 1'b0;
    doReset();

    // R2 directed set-only locks
    busWr(A_LOCK, 32'h1); rdReg(A_LOCK, rd); chk("R2 set bit0", rd, 32'h1);
    busWr(A_LOCK, 32'h0); rdReg(A_LOCK, rd); chk("R2 write 0 no effect", rd, 32'h1);
    eccErr = 1'b1; #1;
    chk("R3 gate closed", {31'h0, breakOut}, 32'h0);
    busWr(A_LOCK, 32'h8); rdReg(A_LOCK, rd); chk("R2 set bit3", rd, 32'h9);
    #1 chk("R3 gate open", {31'h0, breakOut}, 32'h1);
    eccErr = 1'b0; #1;
    chk("R3 follows input", {31'h0, breakOut}, 32'h0);

    // R4 parity flag
    @(negedge clk); parityErr = 1'b1;
    @(negedge clk); parityErr = 1'b0;
    rdReg(A_LOCK, rd); chk("R4 flag set", rd, 32'h109);
    busWr(A_LOCK, 32'h0); rdReg(A_LOCK, rd); chk("R4 write 0 keeps flag", rd, 32'h109);
    busWr(A_LOCK, 32'h100); rdReg(A_LOCK, rd); chk("R4 w1c clears", rd, 32'h9);

    // R5 collision
    @(negedge clk);
    parityErr = 1'b1; busSel = 1'b1; busWrite = 1'b1; busAddr = A_LOCK; busWdata = 32'h100;
    @(negedge clk);
    parityErr = 1'b0; busSel = 1'b0; busWrite = 1'b0;
    rdReg(A_LOCK, rd); chk("R5 set beats clear", rd, 32'h109);

    // R6 reserved bits and other offsets
    busWr(A_LOCK, 32'hFFFF_FFFF); rdReg(A_LOCK, rd); chk("R6 reserved lock bits", rd, 32'h00F);
    rdReg(A_KEY, rd);  chk("R6 key reads 0", rd, 32'h0);
    rdReg(8'h40, rd);  chk("R6 unmapped reads 0", rd, 32'h0);
    busWr(A_ERASE, 32'hFFFF_FFFE); rdReg(A_ERASE, rd); chk("R6 erase reserved", rd, 32'h0);

    // R7 start without key
    weCount = 0;
    busWr(A_ERASE, 32'h1); rdReg(A_ERASE, rd); chk("R7 no key no busy", rd, 32'h0);
    repeat (4) @(negedge clk);
    chk("R7 no key no writes", weCount, 0);

    // R10 keyed erase
    weCount = 0; addrErr = 0;
    unlock();
    busWr(A_ERASE, 32'h1);
    rdReg(A_ERASE, rd); chk("R10 busy after start", rd, 32'h3);
    repeat (DEPTH - 1) @(negedge clk);
    rdReg(A_ERASE, rd); chk("R10 busy at last word", rd, 32'h3);
    @(negedge clk);
    rdReg(A_ERASE, rd); chk("R10 busy cleared", rd, 32'h0);
    chk("R10 word count", weCount, DEPTH);
    chk("R10 address order and zero data", addrErr, 0);

    // R9 unlock spent
    weCount = 0;
    busWr(A_ERASE, 32'h1); rdReg(A_ERASE, rd); chk("R9 second start ignored", rd, 32'h0);
    repeat (3) @(negedge clk);
    chk("R9 no writes", weCount, 0);

    // R8 wrong value, intervening writes
    busWr(A_KEY, 32'hCA); busWr(A_KEY, 32'h11); busWr(A_KEY, 32'h53);
    busWr(A_ERASE, 32'h1); rdReg(A_ERASE, rd); chk("R8 wrong key", rd, 32'h0);
    busWr(A_KEY, 32'hCA); busWr(A_LOCK, 32'h0); busWr(A_KEY, 32'h53);
    busWr(A_ERASE, 32'h1); rdReg(A_ERASE, rd); chk("R8 write between keys", rd, 32'h0);
    unlock(); busWr(A_LOCK, 32'h0);
    busWr(A_ERASE, 32'h1); rdReg(A_ERASE, rd); chk("R8 write before start", rd, 32'h0);
    repeat (3) @(negedge clk);
    chk("R8 no writes", weCount, 0);

    // R11 keyed start during busy
    weCount = 0; addrErr = 0;
    unlock();
    busWr(A_ERASE, 32'h1);
    unlock();
    busWr(A_ERASE, 32'h1);
    repeat (DEPTH - 7) @(negedge clk);
    rdReg(A_ERASE, rd); chk("R11 still busy", rd, 32'h3);
    @(negedge clk);
    rdReg(A_ERASE, rd); chk("R11 ends on time", rd, 32'h0);
    repeat (3) @(negedge clk);
    chk("R11 single erase length", weCount, DEPTH);
    chk("R11 address order", addrErr, 0);

    // R2 cleared by reset
    eccErr = 1'b1;
    doReset();
    rdReg(A_LOCK, rd); chk("R2 reset clears locks", rd, 32'h0);
    #1 chk("R3 gate closed after reset", {31'h0, breakOut}, 32'h0);
    eccErr = 1'b0;

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule